// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor with Hint Bypass

This block predicts, at dispatch time, which older in-flight stores a load must wait for. A table indexed by load or store PC holds a store-set identifier. A second table, indexed by that identifier, holds the store-queue tags of the most recently dispatched stores of the set. An unlabelled load that finds a valid identifier is told to wait on the tags recorded for its set. A load dispatched with a hint flag skips the lookup, is reported independent, uses no read port, and is never trained into the tables.

Loads arrive on several dispatch lanes that use valid/ready. The lookup has a fixed number of read ports per cycle. Lanes are granted in order from lane 0. Once an unlabelled load finds no free port, that lane and every higher lane see `ready` low and must hold their request until a later cycle. Hint loads never need a port. The response for a lane is combinational from table state and is meaningful only in a cycle where that lane's valid and ready are both high. Store dispatch, store issue and violation reports are single-cycle strobes that are always accepted. A programmable period invalidates both tables at once. Two saturating counters report granted lookups and bypassed loads.

Top module: `ssp_predictor`

## Requirements
- R1: After reset, all tables are empty, both counters read zero, and an unlabelled load is reported independent (`rsp_wait`=0, `rsp_slot_vld`=00).
- R2: A granted unlabelled load whose ID entry is valid reports the valid store slots of its set on `rsp_slot_vld`/`rsp_tag`. Bit 0 is the older slot and bit 1 the newer. `rsp_wait` is high when any slot is valid. The response reflects table state as it stood before the current clock edge.
- R3: A load with `ld_hint` set is always accepted when the lanes below it are accepted. It reports `rsp_wait`=0. It adds one to `bypass_cnt` and nothing to `query_cnt`.
- R4: A violation report with `vio_ld_hint` set changes no table entry. A later unlabelled load at that PC stays independent.
- R5: A violation from an unlabelled load trains the ID table. If neither PC has a valid ID, both get the next ID from a counter that starts at 0 and wraps. If one PC has a valid ID, it is copied to the other. If both have one, both take the smaller ID.
- R6: The ID table is indexed by PC bits [7:2] with no tag. PCs that differ by a multiple of 256 share an entry.
- R7: A dispatching store with a valid ID records its tag in its set. The tag fills the older slot if that slot is empty, otherwise the newer slot. When both are full, the older tag is dropped, the newer tag moves to the older slot, and the new tag becomes the newer one.
- R8: An issuing store with a valid ID removes its tag only where the tag matches a recorded slot. When the older slot is removed, the newer tag moves into the older slot.
- R9: With `clr_period`=P≠0, both tables are invalidated every P cycles. P=0 disables clearing. A clear takes priority over training and store recording in the same cycle.
- R10: At most 2 unlabelled loads are granted per cycle, in lane order. The first unlabelled load that finds no port, and every lane above it, sees `ld_ready` low.
- R11: `query_cnt` counts granted unlabelled lookups, `bypass_cnt` counts accepted hint loads, and both saturate at their maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | LANES | Load dispatch request per lane |
| ld_ready | output | LANES | Lane accepted this cycle |
| ld_hint | input | LANES | Load carries the independence hint |
| ld_pc | input | LANES×PC_W | Load PC per lane |
| rsp_wait | output | LANES | Load must wait on a predicted store |
| rsp_slot_vld | output | LANES×2 | Valid store slots for the lane (bit 0 older) |
| rsp_tag | output | LANES×2×TAG_W | Store-queue tags per slot |
| st_valid | input | 1 | Store dispatch strobe |
| st_pc | input | PC_W | Dispatching store PC |
| st_tag | input | TAG_W | Dispatching store queue tag |
| iss_valid | input | 1 | Store issue strobe |
| iss_pc | input | PC_W | Issuing store PC |
| iss_tag | input | TAG_W | Issuing store queue tag |
| vio_valid | input | 1 | Memory-order violation report |
| vio_ld_pc | input | PC_W | PC of violating load |
| vio_st_pc | input | PC_W | PC of the store it overtook |
| vio_ld_hint | input | 1 | Violating load carried the hint |
| clr_period | input | CLR_W | Clear period in cycles, 0 disables |
| query_cnt | output | CNT_W | Saturating count of granted lookups |
| bypass_cnt | output | CNT_W | Saturating count of bypassed loads |

## Verification
The bench targets the three training merges, because each one fails differently. A design that copies the larger ID in the both-valid case would point the merged store at the wrong set, so a later store of that PC would not appear on the load. A design that trained hint violations would turn a bypass-only PC into a waiting load. The slot tests cover a full set, a non-matching issue and removal of the older slot. A wrong shift there would report a stale or missing tag. Port arbitration is tested with hints in different lane positions, to catch a design that charges a port to a hint or lets a later lane pass a stalled one. The bench also tests aliasing of PCs 256 apart, clearing, and counter saturation.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int SLOTS = 2;
  typedef enum logic [1:0] {TR_ALLOC, TR_USE_LD, TR_USE_ST, TR_MERGE} train_e;
endpackage

// File: rtl/ssp_port_arb.sv
module ssp_port_arb #(
  parameter int LANES = 3,
  parameter int PORTS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] valid,
  input  logic [LANES-1:0] hint,
  output logic [LANES-1:0] ready,
  output logic [LANES-1:0] grant,
  output logic [LANES-1:0] bypass
);
  always_comb begin
    int used;
    logic blocked;
    used = 0;
    blocked = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (!blocked && valid[i] && !hint[i] && used == PORTS) blocked = 1'b1;
      ready[i]  = !blocked;
      grant[i]  = !blocked && valid[i] && !hint[i];
      bypass[i] = !blocked && valid[i] && hint[i];
      if (grant[i]) used = used + 1;
    end
  end

  p_port_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) <= PORTS);
  p_hint_no_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & hint) == '0);
endmodule

// File: rtl/ssp_ssit.sv
module ssp_ssit
  import ssp_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int ID_W    = 5,
  parameter int LANES   = 3,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic [LANES-1:0][IDX_W-1:0] lk_idx,
  output logic [LANES-1:0]           lk_vld,
  output logic [LANES-1:0][ID_W-1:0] lk_id,
  input  logic [IDX_W-1:0]           st_idx,
  output logic                       st_vld,
  output logic [ID_W-1:0]            st_id,
  input  logic [IDX_W-1:0]           is_idx,
  output logic                       is_vld,
  output logic [ID_W-1:0]            is_id,
  input  logic                       tr_valid,
  input  logic                       tr_hint,
  input  logic [IDX_W-1:0]           tr_ld_idx,
  input  logic [IDX_W-1:0]           tr_st_idx
);
  logic [ENTRIES-1:0] v_q;
  logic [ID_W-1:0]    id_q [ENTRIES];
  logic [ID_W-1:0]    next_id_q;
  train_e             tr_kind;
  logic [ID_W-1:0]    tr_id;
  logic               tr_go;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lk_vld[i] = v_q[lk_idx[i]];
    assign lk_id[i]  = id_q[lk_idx[i]];
  end
  assign st_vld = v_q[st_idx];
  assign st_id  = id_q[st_idx];
  assign is_vld = v_q[is_idx];
  assign is_id  = id_q[is_idx];

  always_comb begin
    logic lv, sv;
    lv = v_q[tr_ld_idx];
    sv = v_q[tr_st_idx];
    tr_go = tr_valid && !tr_hint && !clear;
    if (lv && sv)  tr_kind = TR_MERGE;
    else if (lv)   tr_kind = TR_USE_LD;
    else if (sv)   tr_kind = TR_USE_ST;
    else           tr_kind = TR_ALLOC;
    case (tr_kind)
      TR_MERGE:  tr_id = (id_q[tr_ld_idx] < id_q[tr_st_idx]) ? id_q[tr_ld_idx] : id_q[tr_st_idx];
      TR_USE_LD: tr_id = id_q[tr_ld_idx];
      TR_USE_ST: tr_id = id_q[tr_st_idx];
      default:   tr_id = next_id_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q       <= '0;
      next_id_q <= '0;
    end else if (clear) begin
      v_q <= '0;
    end else if (tr_go) begin
      v_q[tr_ld_idx] <= 1'b1;
      v_q[tr_st_idx] <= 1'b1;
      if (tr_kind == TR_ALLOC) next_id_q <= next_id_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (tr_go) begin
      id_q[tr_ld_idx] <= tr_id;
      id_q[tr_st_idx] <= tr_id;
    end
  end

  p_hint_no_train_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && tr_hint && !clear) |=> $stable(v_q));
  p_train_links_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && !tr_hint && !clear) |=>
      (v_q[$past(tr_ld_idx)] && v_q[$past(tr_st_idx)] &&
       id_q[$past(tr_ld_idx)] == id_q[$past(tr_st_idx)]));
endmodule

// File: rtl/ssp_lfst.sv
module ssp_lfst
  import ssp_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int TAG_W   = 5,
  parameter int LANES   = 3,
  localparam int ID_W   = $clog2(ENTRIES)
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  clear,
  input  logic [LANES-1:0][ID_W-1:0]            lk_id,
  output logic [LANES-1:0][SLOTS-1:0]           lk_sv,
  output logic [LANES-1:0][SLOTS-1:0][TAG_W-1:0] lk_tag,
  input  logic                                  ins_en,
  input  logic [ID_W-1:0]                       ins_id,
  input  logic [TAG_W-1:0]                      ins_tag,
  input  logic                                  rm_en,
  input  logic [ID_W-1:0]                       rm_id,
  input  logic [TAG_W-1:0]                      rm_tag
);
  logic [SLOTS-1:0]            sv_q  [ENTRIES];
  logic [SLOTS-1:0][TAG_W-1:0] tg_q  [ENTRIES];
  logic [SLOTS-1:0]            sv_nx [ENTRIES];
  logic [SLOTS-1:0][TAG_W-1:0] tg_nx [ENTRIES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lk_sv[i]  = sv_q[lk_id[i]];
    assign lk_tag[i] = tg_q[lk_id[i]];
  end

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      logic [SLOTS-1:0]            s;
      logic [SLOTS-1:0][TAG_W-1:0] t;
      s = sv_q[e];
      t = tg_q[e];
      if (rm_en && rm_id == ID_W'(e)) begin
        if (s[0] && t[0] == rm_tag) begin
          s    = {1'b0, s[1]};
          t[0] = t[1];
        end else if (s[1] && t[1] == rm_tag) begin
          s[1] = 1'b0;
        end
      end
      if (ins_en && ins_id == ID_W'(e)) begin
        if (!s[0]) begin
          s[0] = 1'b1;
          t[0] = ins_tag;
        end else if (!s[1]) begin
          s[1] = 1'b1;
          t[1] = ins_tag;
        end else begin
          t[0] = t[1];
          t[1] = ins_tag;
        end
      end
      sv_nx[e] = s;
      tg_nx[e] = t;
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (!rst_n || clear) sv_q[e] <= '0;
      else                 sv_q[e] <= sv_nx[e];
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) tg_q[e] <= tg_nx[e];
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_chk
    p_slot_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sv_q[e] != 2'b10);
  end
  p_insert_newest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && !rm_en && !clear) |=>
      ((sv_q[$past(ins_id)] == 2'b11) ? tg_q[$past(ins_id)][1] : tg_q[$past(ins_id)][0])
        == $past(ins_tag));
endmodule

// File: rtl/ssp_predictor.sv
module ssp_predictor
  import ssp_pkg::*;
#(
  parameter int PC_W         = 32,
  parameter int SSIT_ENTRIES = 64,
  parameter int LFST_ENTRIES = 32,
  parameter int TAG_W        = 5,
  parameter int LANES        = 3,
  parameter int RD_PORTS     = 2,
  parameter int CNT_W        = 16,
  parameter int CLR_W        = 16,
  localparam int IDX_W       = $clog2(SSIT_ENTRIES),
  localparam int ID_W        = $clog2(LFST_ENTRIES)
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [LANES-1:0]                      ld_valid,
  output logic [LANES-1:0]                      ld_ready,
  input  logic [LANES-1:0]                      ld_hint,
  input  logic [LANES-1:0][PC_W-1:0]            ld_pc,
  output logic [LANES-1:0]                      rsp_wait,
  output logic [LANES-1:0][SLOTS-1:0]           rsp_slot_vld,
  output logic [LANES-1:0][SLOTS-1:0][TAG_W-1:0] rsp_tag,
  input  logic                                  st_valid,
  input  logic [PC_W-1:0]                       st_pc,
  input  logic [TAG_W-1:0]                      st_tag,
  input  logic                                  iss_valid,
  input  logic [PC_W-1:0]                       iss_pc,
  input  logic [TAG_W-1:0]                      iss_tag,
  input  logic                                  vio_valid,
  input  logic [PC_W-1:0]                       vio_ld_pc,
  input  logic [PC_W-1:0]                       vio_st_pc,
  input  logic                                  vio_ld_hint,
  input  logic [CLR_W-1:0]                      clr_period,
  output logic [CNT_W-1:0]                      query_cnt,
  output logic [CNT_W-1:0]                      bypass_cnt
);
  logic [LANES-1:0]                       grant, bypass;
  logic [LANES-1:0][IDX_W-1:0]            lk_idx;
  logic [LANES-1:0]                       ss_vld;
  logic [LANES-1:0][ID_W-1:0]             ss_id;
  logic [LANES-1:0][SLOTS-1:0]            lf_sv;
  logic [LANES-1:0][SLOTS-1:0][TAG_W-1:0] lf_tag;
  logic                                   st_ss_vld, is_ss_vld;
  logic [ID_W-1:0]                        st_ss_id, is_ss_id;
  logic [CLR_W-1:0]                       clr_cnt_q;
  logic                                   clr_fire;

  function automatic logic [IDX_W-1:0] pc_index(input logic [PC_W-1:0] pc);
    return pc[IDX_W+1:2];
  endfunction

  ssp_port_arb #(.LANES(LANES), .PORTS(RD_PORTS)) u_arb (
    .clk(clk), .rst_n(rst_n), .valid(ld_valid), .hint(ld_hint),
    .ready(ld_ready), .grant(grant), .bypass(bypass));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lk_idx[i]       = pc_index(ld_pc[i]);
    assign rsp_slot_vld[i] = (grant[i] && ss_vld[i]) ? lf_sv[i] : '0;
    assign rsp_tag[i]      = lf_tag[i];
    assign rsp_wait[i]     = |rsp_slot_vld[i];
    p_hint_indep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid[i] && ld_ready[i] && ld_hint[i]) |-> !rsp_wait[i]);
    p_clear_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_fire |=> !rsp_wait[i]);
  end

  ssp_ssit #(.ENTRIES(SSIT_ENTRIES), .ID_W(ID_W), .LANES(LANES)) u_ssit (
    .clk(clk), .rst_n(rst_n), .clear(clr_fire),
    .lk_idx(lk_idx), .lk_vld(ss_vld), .lk_id(ss_id),
    .st_idx(pc_index(st_pc)), .st_vld(st_ss_vld), .st_id(st_ss_id),
    .is_idx(pc_index(iss_pc)), .is_vld(is_ss_vld), .is_id(is_ss_id),
    .tr_valid(vio_valid), .tr_hint(vio_ld_hint),
    .tr_ld_idx(pc_index(vio_ld_pc)), .tr_st_idx(pc_index(vio_st_pc)));

  ssp_lfst #(.ENTRIES(LFST_ENTRIES), .TAG_W(TAG_W), .LANES(LANES)) u_lfst (
    .clk(clk), .rst_n(rst_n), .clear(clr_fire),
    .lk_id(ss_id), .lk_sv(lf_sv), .lk_tag(lf_tag),
    .ins_en(st_valid && st_ss_vld), .ins_id(st_ss_id), .ins_tag(st_tag),
    .rm_en(iss_valid && is_ss_vld), .rm_id(is_ss_id), .rm_tag(iss_tag));

  assign clr_fire = (clr_period != '0) && (clr_cnt_q >= clr_period - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_fire || clr_period == '0) clr_cnt_q <= '0;
    else                                       clr_cnt_q <= clr_cnt_q + 1'b1;
  end

  logic [CNT_W:0] q_sum, b_sum;
  assign q_sum = {1'b0, query_cnt}  + (CNT_W+1)'($countones(grant));
  assign b_sum = {1'b0, bypass_cnt} + (CNT_W+1)'($countones(bypass));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      query_cnt  <= '0;
      bypass_cnt <= '0;
    end else begin
      query_cnt  <= q_sum[CNT_W] ? '1 : q_sum[CNT_W-1:0];
      bypass_cnt <= b_sum[CNT_W] ? '1 : b_sum[CNT_W-1:0];
    end
  end

  p_query_sat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (query_cnt == '1) |=> (query_cnt == '1));
  p_bypass_sat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_cnt == '1) |=> (bypass_cnt == '1));
endmodule

// File: tb/tb_ssp_predictor.sv
module tb_ssp_predictor;
  localparam int LANES = 3;
  localparam int CNT_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LANES-1:0] ld_valid = '0, ld_hint = '0, ld_ready, rsp_wait;
  logic [LANES-1:0][31:0] ld_pc = '0;
  logic [LANES-1:0][1:0] rsp_slot_vld;
  logic [LANES-1:0][1:0][4:0] rsp_tag;
  logic st_valid = 0, iss_valid = 0, vio_valid = 0, vio_ld_hint = 0;
  logic [31:0] st_pc = 0, iss_pc = 0, vio_ld_pc = 0, vio_st_pc = 0;
  logic [4:0] st_tag = 0, iss_tag = 0;
  logic [15:0] clr_period = 0;
  logic [CNT_W-1:0] query_cnt, bypass_cnt;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  ssp_predictor #(.LANES(LANES), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_hint(ld_hint), .ld_pc(ld_pc), .rsp_wait(rsp_wait),
    .rsp_slot_vld(rsp_slot_vld), .rsp_tag(rsp_tag),
    .st_valid(st_valid), .st_pc(st_pc), .st_tag(st_tag),
    .iss_valid(iss_valid), .iss_pc(iss_pc), .iss_tag(iss_tag),
    .vio_valid(vio_valid), .vio_ld_pc(vio_ld_pc), .vio_st_pc(vio_st_pc),
    .vio_ld_hint(vio_ld_hint), .clr_period(clr_period),
    .query_cnt(query_cnt), .bypass_cnt(bypass_cnt));

  localparam logic [31:0] L1 = 32'h1004, S1 = 32'h2008, L2 = 32'h100C,
                          L3 = 32'h1010, S3 = 32'h2014, H = 32'h1018;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // single load on lane 0; sample mid-cycle, then advance one cycle
  task automatic probe(input logic [31:0] pc, input logic h,
                       output logic w, output logic [1:0] sv, output logic [9:0] tags);
    ld_valid = 3'b001; ld_hint = {2'b00, h}; ld_pc[0] = pc;
    #1;
    w = rsp_wait[0]; sv = rsp_slot_vld[0]; tags = {rsp_tag[0][1], rsp_tag[0][0]};
    @(negedge clk);
    ld_valid = '0; ld_hint = '0;
  endtask

  task automatic train(input logic [31:0] lp, input logic [31:0] sp, input logic h);
    vio_valid = 1; vio_ld_pc = lp; vio_st_pc = sp; vio_ld_hint = h;
    @(negedge clk);
    vio_valid = 0; vio_ld_hint = 0;
  endtask

  task automatic st_disp(input logic [31:0] pc, input logic [4:0] tag);
    st_valid = 1; st_pc = pc; st_tag = tag;
    @(negedge clk);
    st_valid = 0;
  endtask

  task automatic st_issue(input logic [31:0] pc, input logic [4:0] tag);
    iss_valid = 1; iss_pc = pc; iss_tag = tag;
    @(negedge clk);
    iss_valid = 0;
  endtask

  task automatic t_reset();
    logic w; logic [1:0] sv; logic [9:0] tg;
    chk("R1 query_cnt", query_cnt, 0);
    chk("R1 bypass_cnt", bypass_cnt, 0);
    probe(L1, 0, w, sv, tg);
    chk("R1 empty wait", w, 0);
    chk("R1 empty slots", sv, 0);
  endtask

  task automatic t_alloc_slots();
    logic w; logic [1:0] sv; logic [9:0] tg;
    train(L1, S1, 0);            // R5 alloc -> id 0
    st_disp(S1, 5'd7);
    probe(L1, 0, w, sv, tg);
    chk("R2 wait", w, 1);
    chk("R2 slots", sv, 2'b01);
    chk("R2 tag0", tg[4:0], 7);
    st_disp(S1, 5'd9);
    probe(L1, 0, w, sv, tg);
    chk("R7 two slots", sv, 2'b11);
    chk("R7 tags", tg, {5'd9, 5'd7});
    st_disp(S1, 5'd11);
    probe(L1, 0, w, sv, tg);
    chk("R7 replace oldest", tg, {5'd11, 5'd9});
    chk("R7 full slots", sv, 2'b11);
    probe(L1 + 32'h100, 0, w, sv, tg);
    chk("R6 alias shares set", tg, {5'd11, 5'd9});
  endtask

  task automatic t_issue();
    logic w; logic [1:0] sv; logic [9:0] tg;
    st_issue(S1, 5'd7);
    probe(L1, 0, w, sv, tg);
    chk("R8 mismatch keeps", sv, 2'b11);
    st_issue(S1, 5'd9);
    probe(L1, 0, w, sv, tg);
    chk("R8 removed slots", sv, 2'b01);
    chk("R8 shifted tag", tg[4:0], 11);
  endtask

  task automatic t_train_merge();
    logic w; logic [1:0] sv; logic [9:0] tg;
    train(L2, S1, 0);            // copy id 0 to L2
    probe(L2, 0, w, sv, tg);
    chk("R5 copy wait", w, 1);
    chk("R5 copy tag", tg[4:0], 11);
    train(L3, S3, 0);            // alloc id 1
    st_disp(S3, 5'd3);
    probe(L3, 0, w, sv, tg);
    chk("R5 second alloc tag", tg[4:0], 3);
    train(L2, S3, 0);            // merge: S3 takes id 0
    st_disp(S3, 5'd4);
    probe(L1, 0, w, sv, tg);
    chk("R5 merge smaller", tg, {5'd4, 5'd11});
    train(L3, S1, 0);            // merge: L3 takes id 0
    probe(L3, 0, w, sv, tg);
    chk("R5 merge load side", tg, {5'd4, 5'd11});
  endtask

  task automatic t_hint();
    logic w; logic [1:0] sv; logic [9:0] tg;
    logic [CNT_W-1:0] q0, b0;
    train(H, S1, 1);
    probe(H, 0, w, sv, tg);
    chk("R4 hint not trained", w, 0);
    q0 = query_cnt; b0 = bypass_cnt;
    probe(L1, 1, w, sv, tg);
    chk("R3 hint independent", w, 0);
    chk("R3 bypass count", bypass_cnt, b0 + 1);
    chk("R3 no query", query_cnt, q0);
  endtask

  task automatic t_ports();
    logic [CNT_W-1:0] q0;
    q0 = query_cnt;
    ld_pc = {H, H, H}; ld_valid = 3'b111; ld_hint = 3'b000;
    #1;
    chk("R10 third stalls", ld_ready, 3'b011);
    @(negedge clk);
    chk("R10 two queries", query_cnt, q0 + 2);
    ld_hint = 3'b010;
    #1;
    chk("R10 hint frees port", ld_ready, 3'b111);
    @(negedge clk);
    ld_valid = 3'b101; ld_hint = 3'b000;
    #1;
    chk("R10 gap lane", ld_ready, 3'b111);
    @(negedge clk);
    ld_valid = 3'b111; ld_hint = 3'b100;
    #1;
    chk("R10 hint after full", ld_ready, 3'b111);
    @(negedge clk);
    ld_valid = '0; ld_hint = '0;
  endtask

  task automatic t_clear();
    logic w; logic [1:0] sv; logic [9:0] tg;
    clr_period = 16'd20;
    repeat (4) @(negedge clk);
    probe(L1, 0, w, sv, tg);
    chk("R9 before period", w, 1);
    repeat (25) @(negedge clk);
    clr_period = 0;
    probe(L1, 0, w, sv, tg);
    chk("R9 cleared", w, 0);
    st_disp(S1, 5'd2);
    probe(L1, 0, w, sv, tg);
    chk("R9 tables invalid", w, 0);
  endtask

  task automatic t_sat();
    ld_pc = {H, H, H}; ld_valid = 3'b111; ld_hint = 3'b111;
    repeat (30) @(negedge clk);
    chk("R11 bypass saturates", bypass_cnt, 63);
    ld_hint = 3'b000;
    repeat (35) @(negedge clk);
    chk("R11 query saturates", query_cnt, 63);
    ld_valid = '0;
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alloc_slots();
    t_issue();
    t_train_merge();
    t_hint();
    t_ports();
    t_clear();
    t_sat();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule